// File: doc/BRIEF.md
# Windowed Configuration Space Mapper

This block turns I/O port cycles into configuration transactions by the older window method. Software writes a key byte to one I/O port and a target bus number to a second one. While the key's upper nibble is nonzero, any I/O access to the 4 KB range 0xC000 to 0xCFFF becomes one configuration read or write. The device number comes from I/O address bits 11:8, the dword register index from bits 7:2, and the function number from key bits 3:1. Software closes the window again by writing zero to the key port.

On the I/O side the requester presents one request while `io_rdy` is high and gets exactly one `io_ack` pulse with right-justified read data. On the configuration side the block holds `cfg_req` with stable bus, device, function, register, byte enables and lane-aligned write data until the target answers with `cfg_ack`. If no target answers within `TMO_CYC` cycles, the access is ended as "device not found". A read then returns all ones.

The controller has three states. `ST_IDLE` waits for a request. `ST_CFG` holds a configuration transaction open. `ST_DONE` presents the completion. The transitions are named as follows. IDLE→DONE (`go_local`): a port, unclaimed or closed-window access. IDLE→CFG (`go_cfg`): an access inside an open window. CFG→DONE (`cfg_hit`): the target acknowledged. CFG→DONE (`cfg_timeout`): no answer within the limit. DONE→IDLE (`complete`): `io_ack` is issued.

Top module: `t2_cfg_mapper`

## Requirements
- R1: After reset both the key and the bus registers are zero. A byte read of either port returns 0x00, `io_rdy` is high and `cfg_req` is low.
- R2: A byte write to I/O address 0x0CF8 latches all 8 bits into the key register, and a byte read there returns them. The window is open exactly when key bits 7:4 are nonzero, and the function number is key bits 3:1.
- R3: A byte write to I/O address 0x0CFA latches the bus number, which reads back at that port and drives `cfg_bus`.
- R4: While the window is open, an access with address bits 15:12 = 0xC starts exactly one configuration cycle. That cycle carries device = {0, addr[11:8]}, register = addr[7:2] and `cfg_wr` equal to the I/O direction, and its fields stay stable until it ends.
- R5: `io_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit. Byte enables are 1<<addr[1:0] for a byte, 4'b0011 or 4'b1100 chosen by addr[1] for 16 bits, and 4'b1111 for 32 bits. Write data, right-justified on `io_wdata`, is shifted into the matching byte lanes.
- R6: Configuration read data is returned on `io_rdata` shifted down from the accessed lanes, with the bits above the access width zero.
- R7: The device number presented never has bit 4 set, so only devices 0 to 15 are reachable.
- R8: With the window closed (key bits 7:4 zero, including after a write of 0), window accesses start no configuration cycle, and writes there change no target. Reads there return all ones across the access width.
- R9: A configuration cycle not acknowledged within `TMO_CYC` cycles ends with an all-ones read (access width) and a single completion.
- R10: Accesses outside the window and the two ports, and non-byte accesses at the port addresses, start no configuration cycle and leave both registers unchanged. Reads of them return all ones across the access width.
- R11: Every accepted request yields exactly one single-cycle `io_ack`, and `io_rdy` is low from acceptance until that ack has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O request strobe, taken when io_rdy is high |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Right-justified write data |
| io_rdy | output | 1 | Ready for a new request |
| io_ack | output | 1 | Completion pulse |
| io_rdata | output | 32 | Right-justified read data, valid with io_ack |
| cfg_req | output | 1 | Configuration transaction active |
| cfg_wr | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Lane-aligned target read data |

## Verification
The bench goes after lane placement for byte and 16-bit accesses at every offset. A design that shifts wrongly writes the wrong target byte or returns a neighbour's data. It also checks that a key whose upper nibble is zero but whose function bits are set keeps the window shut; a design that tests the whole byte would start configuration cycles there. A silent target must end in all ones after the timeout, or the design hangs. A 16-bit write aimed at the key port address must leave the key untouched, or the type-1 style port would be corrupted.

// File: rtl/t2cfg_pkg.sv
package t2cfg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } io_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_KEY  = 2'd1,
        TGT_FWD  = 2'd2,
        TGT_WIN  = 2'd3
    } io_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    // Byte lane where an access of the given width starts.
    function automatic logic [1:0] lane_of(input logic [1:0] lo, input logic [1:0] sz);
        logic [1:0] r;
        unique case (sz)
            SZ_BYTE: r = lo;
            SZ_WORD: r = {lo[1], 1'b0};
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    // Mask covering the access width, right-justified.
    function automatic logic [31:0] width_mask(input logic [1:0] sz);
        logic [31:0] m;
        unique case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_WORD: m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/t2_port_regs.sv
module t2_port_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_key,
    input  logic             wr_fwd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] key_q,
    output logic [REG_W-1:0] fwd_q,
    output logic             win_open,
    output logic [2:0]       func
);

    localparam int NIB_LO = REG_W - 4;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            fwd_q <= '0;
        end else begin
            if (wr_key) key_q <= wdata;
            if (wr_fwd) fwd_q <= wdata;
        end
    end

    assign win_open = |key_q[REG_W-1:NIB_LO];
    assign func     = key_q[3:1];

endmodule

// File: rtl/t2_lane_align.sv
module t2_lane_align
    import t2cfg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    addr_lo,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] rdata_in,
    output logic [3:0]    be,
    output logic [DW-1:0] wdata_out,
    output logic [DW-1:0] rdata_out
);

    logic [1:0] lane;
    logic [4:0] shamt;
    logic [3:0] be_base;

    always_comb begin
        lane  = lane_of(addr_lo, size);
        shamt = {lane, 3'b000};
        unique case (size)
            SZ_BYTE: be_base = 4'b0001;
            SZ_WORD: be_base = 4'b0011;
            default: be_base = 4'b1111;
        endcase
        be        = be_base << lane;
        wdata_out = (wdata_in & width_mask(size)) << shamt;
        rdata_out = (rdata_in >> shamt) & width_mask(size);
    end

endmodule

// File: rtl/t2_ctrl.sv
module t2_ctrl
    import t2cfg_pkg::*;
#(
    parameter int TMO_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        go_cfg,
    input  logic        cfg_ack,
    output logic        accept,
    output logic        cap_cfg,
    output logic        tmo_evt,
    output logic        cfg_req,
    output logic        io_ack,
    output logic        io_rdy
);

    localparam int CNT_W = $clog2(TMO_CYC) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    ctrl_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register and timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CFG) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (io_req) state_d = go_cfg ? ST_CFG : ST_DONE;
            ST_CFG:  if (cfg_ack || cnt_q == CNT_LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = 1'b0;
        cap_cfg = 1'b0;
        tmo_evt = 1'b0;
        cfg_req = 1'b0;
        io_ack  = 1'b0;
        io_rdy  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                io_rdy = 1'b1;
                accept = io_req;
            end
            ST_CFG: begin
                cfg_req = 1'b1;
                cap_cfg = cfg_ack;
                tmo_evt = !cfg_ack && (cnt_q == CNT_LAST);
            end
            ST_DONE: io_ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/t2_cfg_mapper.sv
module t2_cfg_mapper
    import t2cfg_pkg::*;
#(
    parameter logic [15:0] KEY_PORT   = 16'h0CF8,
    parameter logic [15:0] FWD_PORT   = 16'h0CFA,
    parameter logic [3:0]  WIN_NIBBLE = 4'hC,
    parameter int          TMO_CYC    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic        io_rdy,
    output logic        io_ack,
    output logic [31:0] io_rdata,
    output logic        cfg_req,
    output logic        cfg_wr,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [5:0]  cfg_reg,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);

    localparam int DW = 32;

    io_tgt_e     tgt;
    logic        accept, cap_cfg, tmo_evt;
    logic        win_open;
    logic [7:0]  key_q, fwd_q;
    logic [2:0]  func;
    logic [15:0] addr_q;
    logic [1:0]  size_q;
    logic        wr_q;
    logic [31:0] wdata_q, rdata_q, rd_aligned;

    // Address decode
    always_comb begin
        if (io_addr == KEY_PORT && io_size == SZ_BYTE)
            tgt = TGT_KEY;
        else if (io_addr == FWD_PORT && io_size == SZ_BYTE)
            tgt = TGT_FWD;
        else if (io_addr[15:12] == WIN_NIBBLE && win_open)
            tgt = TGT_WIN;
        else
            tgt = TGT_NONE;
    end

    t2_port_regs #(.REG_W(8)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_key   (accept && io_wr && tgt == TGT_KEY),
        .wr_fwd   (accept && io_wr && tgt == TGT_FWD),
        .wdata    (io_wdata[7:0]),
        .key_q    (key_q),
        .fwd_q    (fwd_q),
        .win_open (win_open),
        .func     (func)
    );

    t2_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_req  (io_req),
        .go_cfg  (tgt == TGT_WIN),
        .cfg_ack (cfg_ack),
        .accept  (accept),
        .cap_cfg (cap_cfg),
        .tmo_evt (tmo_evt),
        .cfg_req (cfg_req),
        .io_ack  (io_ack),
        .io_rdy  (io_rdy)
    );

    t2_lane_align #(.DW(DW)) u_lane (
        .addr_lo   (addr_q[1:0]),
        .size      (size_q),
        .wdata_in  (wdata_q),
        .rdata_in  (cfg_rdata),
        .be        (cfg_be),
        .wdata_out (cfg_wdata),
        .rdata_out (rd_aligned)
    );

    // Request capture and completion data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= io_addr;
            size_q  <= io_size;
            wr_q    <= io_wr;
            wdata_q <= io_wdata;
            unique case (tgt)
                TGT_KEY: rdata_q <= {24'h0, key_q};
                TGT_FWD: rdata_q <= {24'h0, fwd_q};
                default: rdata_q <= width_mask(io_size);
            endcase
        end else if (cap_cfg) begin
            rdata_q <= rd_aligned;
        end else if (tmo_evt) begin
            rdata_q <= width_mask(size_q);
        end
    end

    assign io_rdata = rdata_q;
    assign cfg_wr   = wr_q;
    assign cfg_bus  = fwd_q;
    assign cfg_func = func;
    assign cfg_dev  = {1'b0, addr_q[11:8]};
    assign cfg_reg  = addr_q[7:2];

endmodule

// File: rtl/t2_cfg_mapper_chk.sv
module t2_cfg_mapper_chk #(
    parameter int TMO_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       io_ack,
    input logic       io_rdy,
    input logic       cfg_req,
    input logic       cfg_ack,
    input logic [4:0] cfg_dev,
    input logic [5:0] cfg_reg,
    input logic [7:0] cfg_bus,
    input logic [3:0] cfg_be,
    input logic [7:0] key_q
);

    localparam int RW = $clog2(TMO_CYC + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (!cfg_req) run_q <= '0;
        else if (run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
    end

    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack);

    p_ack_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> !io_rdy);

    p_dev_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cfg_dev[4]);

    p_window_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (key_q[7:4] != 4'h0));

    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                     cfg_be == 4'b1100 || cfg_be == 4'b1111));

    p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> ($stable(cfg_dev) && $stable(cfg_reg) &&
                                   $stable(cfg_bus) && $stable(cfg_be)));

    p_timeout_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (run_q < RW'(TMO_CYC)));

endmodule

bind t2_cfg_mapper t2_cfg_mapper_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_ack  (io_ack),
    .io_rdy  (io_rdy),
    .cfg_req (cfg_req),
    .cfg_ack (cfg_ack),
    .cfg_dev (cfg_dev),
    .cfg_reg (cfg_reg),
    .cfg_bus (cfg_bus),
    .cfg_be  (cfg_be),
    .key_q   (key_q)
);

// File: tb/tb_t2_cfg_mapper.sv
module tb_t2_cfg_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;
    localparam int TGT_DELAY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_rdy, io_ack;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_wr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0, failures = 0;
    bit done = 0;
    bit silent = 0;
    int starts = 0;
    int wait_cnt = 0;
    logic req_prev = 1'b0;
    logic [31:0] tmem [0:1023];
    logic [4:0]  l_dev;
    logic [2:0]  l_func;
    logic [5:0]  l_reg;
    logic [7:0]  l_bus;
    logic [3:0]  l_be;
    logic [31:0] l_wdata;
    logic        l_wr;

    always #(CLK_PERIOD/2) clk = ~clk;

    t2_cfg_mapper #(.TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_rdy(io_rdy), .io_ack(io_ack), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    // Target model: answers TGT_DELAY cycles into a transaction
    always @(negedge clk) begin
        if (!rst_n) begin
            cfg_ack  = 1'b0;
            wait_cnt = 0;
            req_prev = 1'b0;
        end else begin
            if (cfg_req && !req_prev) starts++;
            req_prev = cfg_req;
            if (cfg_ack) begin
                cfg_ack  = 1'b0;
                wait_cnt = 0;
            end else if (cfg_req && !silent) begin
                if (wait_cnt == TGT_DELAY) begin
                    l_dev = cfg_dev; l_func = cfg_func; l_reg = cfg_reg;
                    l_bus = cfg_bus; l_be = cfg_be; l_wdata = cfg_wdata; l_wr = cfg_wr;
                    if (cfg_wr) begin
                        for (int b = 0; b < 4; b++)
                            if (cfg_be[b]) tmem[{cfg_dev[3:0], cfg_reg}][b*8 +: 8] = cfg_wdata[b*8 +: 8];
                    end
                    cfg_rdata = tmem[{cfg_dev[3:0], cfg_reg}];
                    cfg_ack   = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic io_access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                             input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        int acks = 0;
        bit busy_ok = 1;
        while (!io_rdy) @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        cyc = 0;
        rd  = '0;
        while (acks == 0 && cyc < 100) begin
            cyc++;
            if (io_ack) begin acks++; rd = io_rdata; end
            else if (io_rdy) busy_ok = 0;
            if (acks == 0) @(negedge clk);
        end
        @(negedge clk);
        if (io_ack) acks++;
        // R11: one ack per request, not ready while busy
        chk(acks == 1 && busy_ok, "R11 single ack", acks, 1);
    endtask

    task automatic t_reset();
        logic [31:0] r; int c;
        chk(io_rdy === 1'b1 && cfg_req === 1'b0, "R1 idle after reset", {cfg_req, io_rdy}, 32'h1);
        io_access(0, 16'h0CF8, 2'd0, 0, r, c);
        chk(r == 32'h0, "R1 key reset", r, 0);
        io_access(0, 16'h0CFA, 2'd0, 0, r, c);
        chk(r == 32'h0, "R1 bus reset", r, 0);
    endtask

    task automatic t_regs();
        logic [31:0] r; int c;
        io_access(1, 16'h0CF8, 2'd0, 32'hF4, r, c);
        io_access(0, 16'h0CF8, 2'd0, 0, r, c);
        chk(r == 32'hF4, "R2 key readback", r, 32'hF4);
        io_access(1, 16'h0CFA, 2'd0, 32'h23, r, c);
        io_access(0, 16'h0CFA, 2'd0, 0, r, c);
        chk(r == 32'h23, "R3 bus readback", r, 32'h23);
    endtask

    task automatic t_window();
        logic [31:0] r; int c; int s0;
        s0 = starts;
        io_access(1, 16'hC304, 2'd2, 32'hDEADBEEF, r, c);
        chk(starts == s0 + 1, "R4 one cfg cycle", starts - s0, 1);
        chk(l_dev == 5'd3 && l_reg == 6'd1 && l_wr, "R4 dev/reg/wr", {l_dev, l_reg, l_wr}, {5'd3, 6'd1, 1'b1});
        chk(l_func == 3'd2, "R2 function from key", l_func, 2);
        chk(l_bus == 8'h23, "R3 bus on cfg side", l_bus, 32'h23);
        chk(l_be == 4'hF && l_wdata == 32'hDEADBEEF, "R5 dword lanes", l_wdata, 32'hDEADBEEF);
        io_access(0, 16'hC304, 2'd2, 0, r, c);
        chk(r == 32'hDEADBEEF, "R6 dword read", r, 32'hDEADBEEF);
    endtask

    task automatic t_lanes();
        logic [31:0] r; int c;
        io_access(1, 16'hC306, 2'd0, 32'h5A, r, c);
        chk(l_be == 4'b0100 && l_wdata == 32'h005A0000, "R5 byte lane 2", l_wdata, 32'h005A0000);
        io_access(0, 16'hC306, 2'd0, 0, r, c);
        chk(r == 32'h5A, "R6 byte read lane 2", r, 32'h5A);
        io_access(0, 16'hC306, 2'd1, 0, r, c);
        chk(r == 32'hDE5A && l_be == 4'b1100, "R6 upper word read", r, 32'hDE5A);
        io_access(0, 16'hC305, 2'd0, 0, r, c);
        chk(r == 32'hBE && l_be == 4'b0010, "R5 byte lane 1", r, 32'hBE);
        io_access(0, 16'hC304, 2'd1, 0, r, c);
        chk(r == 32'hBEEF && l_be == 4'b0011, "R6 lower word read", r, 32'hBEEF);
    endtask

    task automatic t_dev15();
        logic [31:0] r; int c;
        io_access(1, 16'h0CF8, 2'd0, 32'hF0, r, c);
        io_access(1, 16'hCF40, 2'd2, 32'h12345678, r, c);
        chk(l_dev == 5'd15 && l_reg == 6'h10 && l_func == 3'd0, "R7 top device", {l_dev, l_reg}, {5'd15, 6'h10});
    endtask

    task automatic t_closed();
        logic [31:0] r; int c; int s0;
        io_access(1, 16'h0CF8, 2'd0, 32'h00, r, c);
        s0 = starts;
        io_access(0, 16'hC304, 2'd2, 0, r, c);
        chk(r == 32'hFFFFFFFF, "R8 closed dword read", r, 32'hFFFFFFFF);
        io_access(0, 16'hC304, 2'd0, 0, r, c);
        chk(r == 32'hFF, "R8 closed byte read", r, 32'hFF);
        io_access(1, 16'hC304, 2'd2, 32'h0, r, c);
        io_access(1, 16'h0CF8, 2'd0, 32'h0E, r, c);
        io_access(0, 16'hC304, 2'd2, 0, r, c);
        chk(r == 32'hFFFFFFFF, "R2 zero nibble keeps closed", r, 32'hFFFFFFFF);
        chk(starts == s0, "R8 no cfg cycle", starts - s0, 0);
        io_access(1, 16'h0CF8, 2'd0, 32'hF4, r, c);
        io_access(0, 16'hC304, 2'd2, 0, r, c);
        chk(r == 32'hDE5ABEEF, "R8 closed write had no effect", r, 32'hDE5ABEEF);
    endtask

    task automatic t_timeout();
        logic [31:0] r; int c; int s0;
        silent = 1;
        s0 = starts;
        io_access(0, 16'hC100, 2'd2, 0, r, c);
        chk(r == 32'hFFFFFFFF, "R9 not found dword", r, 32'hFFFFFFFF);
        chk(starts == s0 + 1 && c >= TMO, "R9 waited for limit", c, TMO);
        io_access(0, 16'hC100, 2'd1, 0, r, c);
        chk(r == 32'hFFFF, "R9 not found word", r, 32'hFFFF);
        silent = 0;
    endtask

    task automatic t_unclaimed();
        logic [31:0] r; int c; int s0;
        s0 = starts;
        io_access(0, 16'h0CF9, 2'd0, 0, r, c);
        chk(r == 32'hFF, "R10 between ports", r, 32'hFF);
        io_access(1, 16'h0CF8, 2'd1, 32'h0000, r, c);
        io_access(0, 16'h0CF8, 2'd0, 0, r, c);
        chk(r == 32'hF4, "R10 word write to key port ignored", r, 32'hF4);
        io_access(1, 16'h0CFA, 2'd2, 32'h0, r, c);
        io_access(0, 16'h0CFA, 2'd0, 0, r, c);
        chk(r == 32'h23, "R10 dword write to bus port ignored", r, 32'h23);
        io_access(0, 16'h1000, 2'd2, 0, r, c);
        chk(r == 32'hFFFFFFFF, "R10 outside read", r, 32'hFFFFFFFF);
        chk(starts == s0, "R10 no cfg cycle", starts - s0, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) tmem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_window();
        t_lanes();
        t_dev15();
        t_closed();
        t_timeout();
        t_unclaimed();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule